// File: doc/BRIEF.md
# Tagged Register Stream Unit

This block sits between an execution core's register ports and its register file. Any register can be bound to one of several streams. A load stream makes reads of its register return successive words fetched from memory. A store stream turns writes to its register into memory stores. Each stream walks memory from a base address by a signed stride for a fixed number of elements. Registers that are not bound behave as ordinary register-file entries, so scratch values stay on chip.

A stream is armed through a configuration port that gives the stream number, the direction, the register index, the base address, the stride and the element count. Load streams fetch ahead into a private 8-entry buffer. A single valid/ready request channel carries all memory traffic. Responses return tagged with the stream number, and up to eight requests can be outstanding at once across all streams. A consumer that reads an armed load register before its data has arrived is held off through the ready signal of the read port.

Top module: `reg_stream_unit`

## Requirements
- R1: A read of a register that no active stream intercepts returns the value last written to it (zero after reset) with `rd_ready_o` high, and neither the read nor such a write issues a memory request.
- R2: Configuring a load stream with count N issues N read requests (`req_we_o` = 0, `req_id_o` = stream number) at addresses base, base+stride, base+2*stride, and so on, where stride is a 16-bit two's-complement value.
- R3: Reads of a load-bound register return the loaded words in address order. While that stream's buffer is empty, `rd_ready_o` is low and nothing is consumed.
- R4: A load stream stops issuing requests once its buffered entries plus its outstanding requests reach 8. It resumes as the consumer drains the buffer.
- R5: No more than 8 requests are outstanding at once over all streams, and `req_valid_o` stays low while 8 are outstanding.
- R6: Each accepted write to a store-bound register issues one write request (`req_we_o` = 1) carrying the written data. Addresses advance by the stride from the base, in the order the writes were made.
- R7: A stream releases its register once its count is used up: the last read for a load stream, the last accepted write for a store stream. From then on the register reads and writes the register file.
- R8: `done_o[s]` is high after reset. It goes low while stream s is armed and rises only when the count is used up and every response for the stream has returned.
- R9: A configuration aimed at a stream whose `done_o` is low is ignored.
- R10: A pending store has priority over load prefetch on the request channel. A write to a store-bound register is held (`wr_ready_o` low) while the request is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Arm the selected stream |
| cfg_sel_i | input | 2 | Stream number to configure |
| cfg_dir_i | input | 1 | 0 load stream, 1 store stream |
| cfg_reg_i | input | 5 | Register index bound to the stream |
| cfg_base_i | input | 32 | First element address |
| cfg_stride_i | input | 16 | Signed address step per element |
| cfg_count_i | input | 16 | Element count (0 leaves the stream idle) |
| rd_en_i | input | 1 | Register read request |
| rd_idx_i | input | 5 | Register read index |
| rd_data_o | output | 32 | Read data |
| rd_ready_o | output | 1 | Read data valid; low stalls the reader |
| wr_en_i | input | 1 | Register write request |
| wr_idx_i | input | 5 | Register write index |
| wr_data_i | input | 32 | Register write data |
| wr_ready_o | output | 1 | Write accepted this cycle |
| req_valid_o | output | 1 | Memory request valid |
| req_ready_i | input | 1 | Memory request accepted |
| req_we_o | output | 1 | 1 store, 0 load |
| req_addr_o | output | 32 | Request address |
| req_wdata_o | output | 32 | Store data |
| req_id_o | output | 2 | Stream that owns the request |
| resp_valid_i | input | 1 | Memory response valid |
| resp_id_i | input | 2 | Stream the response belongs to |
| resp_data_i | input | 32 | Load response data |
| done_o | output | 4 | Per-stream idle and drained |

## Verification
The assertions assume that memory responds only to requests it has accepted and that responses for any one stream come back in request order. They also assume that no two active streams are bound to the same register. The bench memory model keeps to this. It queues every accepted request and answers from a single in-order queue after a fixed latency, or holds all answers when a test asks it to. Each test binds distinct registers to its streams.

// File: rtl/rsu_pkg.sv
package rsu_pkg;
  typedef enum logic {
    DIR_LOAD  = 1'b0,
    DIR_STORE = 1'b1
  } dir_e;
endpackage

// File: rtl/rsu_fifo.sv
module rsu_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic [CNT_W-1:0] count_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] ptr_next(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= ptr_next(rd_ptr_q);
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= data_i;
  end

  assign data_o  = mem_q[rd_ptr_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/rsu_regfile.sv
module rsu_regfile #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [REG_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
    end else if (we_i) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = regs_q[raddr_i];
endmodule

// File: rtl/rsu_arb.sv
module rsu_arb #(
  parameter int N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic         any_o
);
  // lowest index wins
  always_comb begin
    gnt_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
      end
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/rsu_stream.sv
module rsu_stream
  import rsu_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 32,
  parameter int STRIDE_W = 16,
  parameter int CNT_W    = 16,
  parameter int REG_W    = 5,
  parameter int DEPTH    = 8,
  parameter int MAX_OUT  = 8,
  localparam int PEND_W  = $clog2(((DEPTH > MAX_OUT) ? DEPTH : MAX_OUT) + 1),
  localparam int FCNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_i,
  input  dir_e                cfg_dir_i,
  input  logic [REG_W-1:0]    cfg_reg_i,
  input  logic [ADDR_W-1:0]   cfg_base_i,
  input  logic [STRIDE_W-1:0] cfg_stride_i,
  input  logic [CNT_W-1:0]    cfg_count_i,
  input  logic                fire_i,
  input  logic                pop_i,
  input  logic                resp_i,
  input  logic [DATA_W-1:0]   resp_data_i,
  output logic                active_o,
  output dir_e                dir_o,
  output logic [REG_W-1:0]    reg_o,
  output logic [ADDR_W-1:0]   addr_o,
  output logic                want_o,
  output logic [DATA_W-1:0]   head_o,
  output logic                head_valid_o,
  output logic                done_o
);
  dir_e                dir_q;
  logic [REG_W-1:0]    reg_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [STRIDE_W-1:0] stride_q;
  logic [CNT_W-1:0]    issue_left_q, read_left_q;
  logic [PEND_W-1:0]   pend_q;
  logic [FCNT_W-1:0]   fcnt;
  logic [ADDR_W-1:0]   stride_ext;
  logic                cfg_ok, is_load;

  assign is_load    = (dir_q == DIR_LOAD);
  assign stride_ext = {{(ADDR_W - STRIDE_W){stride_q[STRIDE_W-1]}}, stride_q};
  assign cfg_ok     = cfg_i && done_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q        <= DIR_LOAD;
      reg_q        <= '0;
      addr_q       <= '0;
      stride_q     <= '0;
      issue_left_q <= '0;
      read_left_q  <= '0;
    end else if (cfg_ok) begin
      dir_q        <= cfg_dir_i;
      reg_q        <= cfg_reg_i;
      addr_q       <= cfg_base_i;
      stride_q     <= cfg_stride_i;
      issue_left_q <= cfg_count_i;
      read_left_q  <= (cfg_dir_i == DIR_LOAD) ? cfg_count_i : '0;
    end else begin
      if (fire_i) begin
        addr_q       <= addr_q + stride_ext;
        issue_left_q <= issue_left_q - 1'b1;
      end
      if (pop_i) read_left_q <= read_left_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_q + PEND_W'(fire_i) - PEND_W'(resp_i);
  end

  rsu_fifo #(
    .WIDTH(DATA_W),
    .DEPTH(DEPTH)
  ) i_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (resp_i && is_load),
    .data_i (resp_data_i),
    .pop_i  (pop_i),
    .data_o (head_o),
    .count_o(fcnt)
  );

  assign active_o     = is_load ? (read_left_q != '0) : (issue_left_q != '0);
  assign done_o       = !active_o && (pend_q == '0);
  // buffered plus in flight never exceeds the buffer
  assign want_o       = is_load && (issue_left_q != '0) &&
                        ((32'(fcnt) + 32'(pend_q)) < DEPTH);
  assign head_valid_o = (fcnt != '0);
  assign dir_o        = dir_q;
  assign reg_o        = reg_q;
  assign addr_o       = addr_q;
endmodule

// File: rtl/reg_stream_unit.sv
module reg_stream_unit
  import rsu_pkg::*;
#(
  parameter int NUM_STREAMS = 4,
  parameter int NUM_REGS    = 32,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 32,
  parameter int STRIDE_W    = 16,
  parameter int CNT_W       = 16,
  parameter int FIFO_DEPTH  = 8,
  parameter int MAX_OUT     = 8,
  localparam int SEL_W      = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1,
  localparam int REG_W      = $clog2(NUM_REGS),
  localparam int OUT_W      = $clog2(MAX_OUT + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cfg_we_i,
  input  logic [SEL_W-1:0]       cfg_sel_i,
  input  logic                   cfg_dir_i,
  input  logic [REG_W-1:0]       cfg_reg_i,
  input  logic [ADDR_W-1:0]      cfg_base_i,
  input  logic [STRIDE_W-1:0]    cfg_stride_i,
  input  logic [CNT_W-1:0]       cfg_count_i,
  input  logic                   rd_en_i,
  input  logic [REG_W-1:0]       rd_idx_i,
  output logic [DATA_W-1:0]      rd_data_o,
  output logic                   rd_ready_o,
  input  logic                   wr_en_i,
  input  logic [REG_W-1:0]       wr_idx_i,
  input  logic [DATA_W-1:0]      wr_data_i,
  output logic                   wr_ready_o,
  output logic                   req_valid_o,
  input  logic                   req_ready_i,
  output logic                   req_we_o,
  output logic [ADDR_W-1:0]      req_addr_o,
  output logic [DATA_W-1:0]      req_wdata_o,
  output logic [SEL_W-1:0]       req_id_o,
  input  logic                   resp_valid_i,
  input  logic [SEL_W-1:0]       resp_id_i,
  input  logic [DATA_W-1:0]      resp_data_i,
  output logic [NUM_STREAMS-1:0] done_o
);
  logic [NUM_STREAMS-1:0] act, want, head_valid, rd_hit, wr_hit;
  logic [NUM_STREAMS-1:0] ld_gnt, st_gnt, sel, fire_s, pop_s, resp_s, cfg_s;
  logic [ADDR_W-1:0]      s_addr [NUM_STREAMS];
  logic [DATA_W-1:0]      s_head [NUM_STREAMS];
  logic [REG_W-1:0]       s_reg  [NUM_STREAMS];
  dir_e                   s_dir  [NUM_STREAMS];
  logic [DATA_W-1:0]      rf_rdata;
  logic [OUT_W-1:0]       out_q;
  logic                   ld_any, st_any, st_req, out_ok, fire, rf_we;

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_stream
    assign cfg_s[s]  = cfg_we_i && (cfg_sel_i == SEL_W'(s));
    assign resp_s[s] = resp_valid_i && (resp_id_i == SEL_W'(s));
    assign rd_hit[s] = act[s] && (s_dir[s] == DIR_LOAD) && (s_reg[s] == rd_idx_i);
    assign wr_hit[s] = act[s] && (s_dir[s] == DIR_STORE) && (s_reg[s] == wr_idx_i);
    assign pop_s[s]  = rd_en_i && rd_hit[s] && head_valid[s];
    assign fire_s[s] = fire && sel[s];

    rsu_stream #(
      .DATA_W  (DATA_W),
      .ADDR_W  (ADDR_W),
      .STRIDE_W(STRIDE_W),
      .CNT_W   (CNT_W),
      .REG_W   (REG_W),
      .DEPTH   (FIFO_DEPTH),
      .MAX_OUT (MAX_OUT)
    ) i_stream (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cfg_i       (cfg_s[s]),
      .cfg_dir_i   (dir_e'(cfg_dir_i)),
      .cfg_reg_i   (cfg_reg_i),
      .cfg_base_i  (cfg_base_i),
      .cfg_stride_i(cfg_stride_i),
      .cfg_count_i (cfg_count_i),
      .fire_i      (fire_s[s]),
      .pop_i       (pop_s[s]),
      .resp_i      (resp_s[s]),
      .resp_data_i (resp_data_i),
      .active_o    (act[s]),
      .dir_o       (s_dir[s]),
      .reg_o       (s_reg[s]),
      .addr_o      (s_addr[s]),
      .want_o      (want[s]),
      .head_o      (s_head[s]),
      .head_valid_o(head_valid[s]),
      .done_o      (done_o[s])
    );
  end

  rsu_arb #(.N(NUM_STREAMS)) i_ld_arb (.req_i(want),   .gnt_o(ld_gnt), .any_o(ld_any));
  rsu_arb #(.N(NUM_STREAMS)) i_st_arb (.req_i(wr_hit), .gnt_o(st_gnt), .any_o(st_any));

  rsu_regfile #(
    .NUM_REGS(NUM_REGS),
    .DATA_W  (DATA_W)
  ) i_regfile (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (rf_we),
    .waddr_i(wr_idx_i),
    .wdata_i(wr_data_i),
    .raddr_i(rd_idx_i),
    .rdata_o(rf_rdata)
  );

  // read side: stream buffer head overrides the register file
  always_comb begin
    rd_data_o  = rf_rdata;
    rd_ready_o = 1'b1;
    for (int s = 0; s < NUM_STREAMS; s++) begin
      if (rd_hit[s]) begin
        rd_data_o  = s_head[s];
        rd_ready_o = head_valid[s];
      end
    end
  end

  // request side: stores first, keeps program order of writes
  assign st_req      = wr_en_i && st_any;
  assign out_ok      = (out_q < OUT_W'(MAX_OUT));
  assign req_valid_o = out_ok && (st_req || ld_any);
  assign sel         = st_req ? st_gnt : ld_gnt;
  assign fire        = req_valid_o && req_ready_i;
  assign req_we_o    = st_req;
  assign req_wdata_o = wr_data_i;
  assign wr_ready_o  = st_any ? (out_ok && req_ready_i) : 1'b1;
  assign rf_we       = wr_en_i && !st_any;

  always_comb begin
    req_addr_o = '0;
    req_id_o   = '0;
    for (int s = 0; s < NUM_STREAMS; s++) begin
      if (sel[s]) begin
        req_addr_o = s_addr[s];
        req_id_o   = SEL_W'(s);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= '0;
    else         out_q <= out_q + OUT_W'(fire) - OUT_W'(resp_valid_i);
  end
endmodule

// File: rtl/rsu_chk.sv
module rsu_chk #(
  parameter int NUM_STREAMS = 4,
  parameter int DATA_W      = 32,
  parameter int MAX_OUT     = 8,
  parameter int SEL_W       = 2
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   req_valid_o,
  input logic                   req_ready_i,
  input logic                   req_we_o,
  input logic [SEL_W-1:0]       req_id_o,
  input logic [DATA_W-1:0]      req_wdata_o,
  input logic                   wr_en_i,
  input logic [DATA_W-1:0]      wr_data_i,
  input logic                   wr_ready_o,
  input logic                   resp_valid_i,
  input logic [SEL_W-1:0]       resp_id_i,
  input logic [NUM_STREAMS-1:0] done_o
);
  logic       fire;
  logic [7:0] tot_q;
  logic [7:0] pc_q [NUM_STREAMS];

  assign fire = req_valid_o && req_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tot_q <= '0;
    else         tot_q <= tot_q + 8'(fire) - 8'(resp_valid_i);
  end

  a_r5_outstanding_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tot_q <= 8'(MAX_OUT));

  a_r5_no_req_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tot_q == 8'(MAX_OUT)) |-> !req_valid_o);

  a_r6_store_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_we_o) |-> (wr_en_i && req_wdata_o == wr_data_i));

  a_r10_store_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && req_valid_o && req_we_o && !req_ready_i) |-> !wr_ready_o);

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_pc
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pc_q[s] <= '0;
      else pc_q[s] <= pc_q[s] + 8'(fire && req_id_o == SEL_W'(s))
                              - 8'(resp_valid_i && resp_id_i == SEL_W'(s));
    end

    a_r8_done_drained: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o[s] |-> (pc_q[s] == '0));
  end
endmodule

bind reg_stream_unit rsu_chk #(
  .NUM_STREAMS(NUM_STREAMS),
  .DATA_W     (DATA_W),
  .MAX_OUT    (MAX_OUT),
  .SEL_W      (SEL_W)
) i_rsu_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_o (req_valid_o),
  .req_ready_i (req_ready_i),
  .req_we_o    (req_we_o),
  .req_id_o    (req_id_o),
  .req_wdata_o (req_wdata_o),
  .wr_en_i     (wr_en_i),
  .wr_data_i   (wr_data_i),
  .wr_ready_o  (wr_ready_o),
  .resp_valid_i(resp_valid_i),
  .resp_id_i   (resp_id_i),
  .done_o      (done_o)
);

// File: tb/test_reg_stream_unit.sv
module test_reg_stream_unit;
  localparam int LAT = 3;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        cfg_we_i = 0;
  logic [1:0]  cfg_sel_i = 0;
  logic        cfg_dir_i = 0;
  logic [4:0]  cfg_reg_i = 0;
  logic [31:0] cfg_base_i = 0;
  logic [15:0] cfg_stride_i = 0;
  logic [15:0] cfg_count_i = 0;
  logic        rd_en_i = 0;
  logic [4:0]  rd_idx_i = 0;
  logic [31:0] rd_data_o;
  logic        rd_ready_o;
  logic        wr_en_i = 0;
  logic [4:0]  wr_idx_i = 0;
  logic [31:0] wr_data_i = 0;
  logic        wr_ready_o;
  logic        req_valid_o;
  logic        req_ready_i = 0;
  logic        req_we_o;
  logic [31:0] req_addr_o;
  logic [31:0] req_wdata_o;
  logic [1:0]  req_id_o;
  logic        resp_valid_i = 0;
  logic [1:0]  resp_id_i = 0;
  logic [31:0] resp_data_i = 0;
  logic [3:0]  done_o;

  always #5 clk_i = ~clk_i;

  reg_stream_unit i_reg_stream_unit (.*);

  typedef struct {logic we; logic [31:0] addr; logic [31:0] data; logic [1:0] id;} exp_t;
  typedef struct {int due; logic [1:0] id; logic we; logic [31:0] addr;} pend_t;
  exp_t  exp_q[$];
  pend_t pq[$];

  int    errors = 0, checks = 0, cyc = 0, nfire = 0;
  bit    mem_ready = 1, mem_hold = 0;
  logic [31:0] d;
  int    base_n;

  function automatic logic [31:0] mem_f(logic [31:0] a);
    return a * 32'd3 + 32'h11;
  endfunction

  task automatic check(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // memory model and request monitor
  initial begin
    pend_t p;
    exp_t  e;
    forever begin
      @(negedge clk_i);
      cyc++;
      resp_valid_i = 1'b0;
      if (!mem_hold && pq.size() > 0 && pq[0].due <= cyc) begin
        p = pq.pop_front();
        resp_valid_i = 1'b1;
        resp_id_i    = p.id;
        resp_data_i  = p.we ? 32'h0 : mem_f(p.addr);
      end
      req_ready_i = mem_ready;
      #3;
      if (rst_ni && req_valid_o && req_ready_i) begin
        nfire++;
        if (exp_q.size() == 0) begin
          check(0, "R1 R9 unexpected request", req_addr_o, 32'h0);
        end else begin
          e = exp_q.pop_front();
          check(req_we_o == e.we && req_addr_o == e.addr && req_id_o == e.id &&
                (!e.we || req_wdata_o == e.data),
                e.we ? "R6 store request" : "R2 load request", req_addr_o, e.addr);
        end
        pq.push_back('{due: cyc + LAT, id: req_id_o, we: req_we_o, addr: req_addr_o});
      end
    end
  end

  task automatic cfg(int s, bit dir, int r, logic [31:0] base, int stride, int count);
    @(negedge clk_i);
    cfg_we_i = 1; cfg_sel_i = 2'(s); cfg_dir_i = dir; cfg_reg_i = 5'(r);
    cfg_base_i = base; cfg_stride_i = 16'(stride); cfg_count_i = 16'(count);
    @(posedge clk_i); #1 cfg_we_i = 0;
  endtask

  task automatic push_ld(int s, logic [31:0] base, int stride, int n);
    for (int i = 0; i < n; i++) exp_q.push_back('{1'b0, base + 32'(i * stride), 32'h0, 2'(s)});
  endtask

  task automatic do_write(int r, logic [31:0] v);
    @(negedge clk_i);
    wr_en_i = 1; wr_idx_i = 5'(r); wr_data_i = v;
    #3;
    while (!wr_ready_o) begin @(negedge clk_i); #3; end
    @(posedge clk_i); #1 wr_en_i = 0;
  endtask

  task automatic do_read(int r, output logic [31:0] v);
    @(negedge clk_i);
    rd_en_i = 1; rd_idx_i = 5'(r);
    #3;
    while (!rd_ready_o) begin @(negedge clk_i); #3; end
    v = rd_data_o;
    @(posedge clk_i); #1 rd_en_i = 0;
  endtask

  task automatic read_chk(int r, logic [31:0] exp, string rq);
    logic [31:0] v;
    do_read(r, v);
    check(v == exp, rq, v, exp);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_ni = 0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1;

    // reset state
    @(negedge clk_i); rd_idx_i = 7; #3;
    check(done_o == 4'hF, "R8 done after reset", 32'(done_o), 32'hF);
    check(!req_valid_o, "R5 idle request", 32'(req_valid_o), 0);
    check(rd_ready_o && rd_data_o == 0, "R1 reset register", rd_data_o, 0);

    // R1 plain register traffic
    do_write(3, 32'hCAFE0003);
    do_write(9, 32'h0BAD0009);
    read_chk(3, 32'hCAFE0003, "R1 plain reg 3");
    read_chk(9, 32'h0BAD0009, "R1 plain reg 9");

    // R2 R3 R7 load stream, positive stride, stall on empty buffer
    do_write(5, 32'h1234);
    push_ld(0, 32'h100, 4, 3);
    cfg(0, 0, 5, 32'h100, 4, 3);
    @(negedge clk_i); rd_idx_i = 5; #3;
    check(!rd_ready_o, "R3 stall on empty buffer", 32'(rd_ready_o), 0);
    check(done_o[0] == 0, "R8 armed stream not done", 32'(done_o[0]), 0);
    for (int i = 0; i < 3; i++) read_chk(5, mem_f(32'h100 + 32'(4 * i)), "R3 load data order");
    read_chk(5, 32'h1234, "R7 load tag released");

    // R2 negative stride
    push_ld(1, 32'h200, -8, 2);
    cfg(1, 0, 6, 32'h200, -8, 2);
    read_chk(6, mem_f(32'h200), "R2 negative stride first");
    read_chk(6, mem_f(32'h1F8), "R2 negative stride second");

    // R4 per-stream prefetch limit
    base_n = nfire;
    push_ld(2, 32'h1000, 4, 20);
    cfg(2, 0, 10, 32'h1000, 4, 20);
    repeat (30) @(negedge clk_i);
    check(nfire - base_n == 8, "R4 prefetch stops at buffer size", 32'(nfire - base_n), 8);
    read_chk(10, mem_f(32'h1000), "R4 first element");
    repeat (10) @(negedge clk_i);
    check(nfire - base_n == 9, "R4 prefetch resumes after drain", 32'(nfire - base_n), 9);
    for (int i = 1; i < 20; i++) read_chk(10, mem_f(32'h1000 + 32'(4 * i)), "R4 stream data");

    // R5 global in-flight limit
    mem_hold = 1;
    base_n = nfire;
    push_ld(0, 32'h2000, 4, 8);
    push_ld(1, 32'h3000, 4, 8);
    cfg(0, 0, 11, 32'h2000, 4, 8);
    cfg(1, 0, 12, 32'h3000, 4, 8);
    repeat (20) @(negedge clk_i);
    check(nfire - base_n == 8, "R5 in-flight cap", 32'(nfire - base_n), 8);
    mem_hold = 0;
    for (int i = 0; i < 8; i++) read_chk(11, mem_f(32'h2000 + 32'(4 * i)), "R5 stream 0 data");
    for (int i = 0; i < 8; i++) read_chk(12, mem_f(32'h3000 + 32'(4 * i)), "R5 stream 1 data");
    repeat (5) @(negedge clk_i);
    check(done_o == 4'hF, "R8 all loads done", 32'(done_o), 32'hF);

    // R6 R7 R8 R9 store stream
    mem_hold = 1;
    exp_q.push_back('{1'b1, 32'h4000, 32'hD0D0_0001, 2'd3});
    exp_q.push_back('{1'b1, 32'h4010, 32'hD0D0_0002, 2'd3});
    cfg(3, 1, 20, 32'h4000, 16, 2);
    do_write(20, 32'hD0D0_0001);
    do_write(20, 32'hD0D0_0002);
    do_write(20, 32'h77);
    @(negedge clk_i); #3;
    check(done_o[3] == 0, "R8 done waits for responses", 32'(done_o[3]), 0);
    cfg(3, 0, 21, 32'h9000, 4, 2);
    mem_hold = 0;
    repeat (10) @(negedge clk_i);
    #3;
    check(done_o[3] == 1, "R8 done after responses", 32'(done_o[3]), 1);
    read_chk(20, 32'h77, "R7 store tag released");
    read_chk(21, 32'h0, "R9 config while busy ignored");
    check(exp_q.size() == 0, "R6 stores all issued", 32'(exp_q.size()), 0);

    // R10 store priority and backpressure
    mem_ready = 0;
    cfg(0, 0, 13, 32'h5000, 4, 2);
    cfg(1, 1, 14, 32'h6000, 4, 1);
    @(negedge clk_i); #3;
    check(req_valid_o && !req_we_o, "R10 load waiting", 32'(req_we_o), 0);
    @(negedge clk_i);
    wr_en_i = 1; wr_idx_i = 14; wr_data_i = 32'hBEEF;
    #3;
    check(req_valid_o && req_we_o && req_addr_o == 32'h6000, "R10 store wins channel",
          req_addr_o, 32'h6000);
    check(!wr_ready_o, "R10 write held without ready", 32'(wr_ready_o), 0);
    exp_q.push_back('{1'b1, 32'h6000, 32'hBEEF, 2'd1});
    push_ld(0, 32'h5000, 4, 2);
    mem_ready = 1;
    do_write(14, 32'hBEEF);
    read_chk(13, mem_f(32'h5000), "R10 load after store 0");
    read_chk(13, mem_f(32'h5004), "R10 load after store 1");

    repeat (20) @(negedge clk_i);
    #3;
    check(exp_q.size() == 0, "R2 all expected requests seen", 32'(exp_q.size()), 0);
    check(done_o == 4'hF, "R8 all streams drained", 32'(done_o), 32'hF);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule